// File: doc/BRIEF.md
# I2C-Timed Track/Hold and SAR Conversion Sequencer

This block sits behind the serial port of an I2C-slave analog-to-digital converter. It controls when the analog sample is taken and runs a 10-bit successive-approximation search. It watches the bus lines, counts SCL pulses from each START and compares the 7-bit address with the device address. When a matched read request arrives, it raises a track strobe. It later switches to hold on an SCL edge that depends on the mode. It then resolves the result one bit per conversion clock against an external comparator.

Two timing modes are supported. In the first mode the conversion clock is a local divided tick. The block pulls SCL low until the result is complete, so the bus master must wait. In the second mode no clock stretching is done, and every rising SCL edge while the result byte is read moves the search by one bit. A channel field and a differential flag steer the input multiplexer. In single-ended use the negative side goes to ground. In differential use it goes to the partner channel, which is the selected number with its lowest bit inverted.

Top module: `i2c_sar_seq`

## Requirements
- R1: After reset, track, hold, scl_stretch and result_valid are all low.
- R2: With mode_ext=0, track rises after the 8th rising SCL edge following START, but only when the first seven bits match dev_addr (sent MSB first) and the 8th bit is 1 (read).
- R3: With mode_ext=0, the falling SCL edge that ends the 9th pulse (the acknowledge slot) lowers track, raises hold and asserts scl_stretch (1 means pull SCL low).
- R4: With mode_ext=0, one trial step is taken every CONV_DIV system clocks. scl_stretch stays high for exactly NB*CONV_DIV cycles and is released in the same cycle that result_valid pulses.
- R5: With mode_ext=1, track rises after the 8th rising edge of a matched read. Hold starts at the 11th rising edge, which is the 2nd pulse of the first result byte. scl_stretch never asserts in this mode.
- R6: With mode_ext=1, each later rising SCL edge takes exactly one trial step, so result_valid comes on the 10th edge after hold starts and not before.
- R7: When hold starts, dac_code holds only the MSB trial (512 for NB=10). At each step the current bit is kept if cmp_in=1 (input at or above dac_code) and cleared otherwise, and the next lower bit is then set. The final code equals the input level.
- R8: result_valid is a single-cycle pulse for each completed conversion, and result holds the final code.
- R9: A write request (8th bit 0) or an address mismatch never raises track or hold.
- R10: A STOP or a repeated START in any phase drops track and hold and abandons the conversion without a result_valid pulse.
- R11: mux_pos equals chan_sel. With diff_en=0, neg_gnd=1 and mux_neg=0. With diff_en=1, neg_gnd=0 and mux_neg is chan_sel with bit 0 inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line as seen on the bus |
| sda_in | input | 1 | SDA line as seen on the bus |
| dev_addr | input | 7 | Device address to match |
| mode_ext | input | 1 | 1 = SCL is the conversion clock, 0 = local tick with stretching |
| chan_sel | input | CHW | Input channel number |
| diff_en | input | 1 | 1 = differential pair, 0 = single-ended to ground |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| track | output | 1 | Track switch control |
| hold | output | 1 | Hold switch control, high during conversion |
| scl_stretch | output | 1 | Request to pull SCL low |
| mux_pos | output | CHW | Positive mux select |
| mux_neg | output | CHW | Negative mux select |
| neg_gnd | output | 1 | Negative input tied to ground |
| dac_code | output | NB | Current trial code for the capacitive DAC |
| result | output | NB | Last completed conversion |
| result_valid | output | 1 | One-cycle pulse when result updates |

## Verification
The checks assume a master that honours clock stretching. They also assume that SDA changes only while SCL is low, except at START and STOP, and that every SCL phase lasts longer than the two-flop synchronizer delay. The pulse and release properties depend on these, because a START cannot be seen while the block is holding SCL low. The bench master drives the line as a wired-AND with scl_stretch and holds every half period for ten system clocks. It waits for the line to read high before it counts a high phase. It changes SDA a few clocks after each falling edge, and it keeps mode_ext and the channel inputs steady for the whole of each transaction.

// File: rtl/i2c_sar_seq.sv
module i2c_sar_seq #(
  parameter int NB       = 10,
  parameter int CONV_DIV = 4,
  parameter int CHW      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_in,
  input  logic           sda_in,
  input  logic [6:0]     dev_addr,
  input  logic           mode_ext,
  input  logic [CHW-1:0] chan_sel,
  input  logic           diff_en,
  input  logic           cmp_in,
  output logic           track,
  output logic           hold,
  output logic           scl_stretch,
  output logic [CHW-1:0] mux_pos,
  output logic [CHW-1:0] mux_neg,
  output logic           neg_gnd,
  output logic [NB-1:0]  dac_code,
  output logic [NB-1:0]  result,
  output logic           result_valid
);
  localparam int BW        = (NB > 1) ? $clog2(NB) : 1;
  localparam int DW        = $clog2(CONV_DIV) + 1;
  localparam int EW        = $clog2(NB + 12) + 1;
  localparam int RW_EDGE   = 8;
  localparam int ACK_EDGE  = 9;
  localparam int HOLD_EDGE = ACK_EDGE + 2;
  localparam logic [NB-1:0] MSB_TRIAL = {1'b1, {(NB-1){1'b0}}};

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_TRK_I, S_CNV_I, S_TRK_E, S_CNV_E, S_WAIT
  } st_t;

  st_t           state;
  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  logic [EW-1:0] edges;
  logic [6:0]    shift;
  logic [NB-1:0] sar, sar_nx;
  logic [BW-1:0] bi;
  logic [DW-1:0] div;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire [EW-1:0] en = edges + 1'b1;
  wire addr_ok = (shift == dev_addr);
  wire step = (state == S_CNV_I && div == DW'(CONV_DIV - 1)) ||
              (state == S_CNV_E && scl_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_comb begin
    sar_nx = sar;
    if (!cmp_in) sar_nx[bi] = 1'b0;
    if (bi != '0) sar_nx[bi - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      edges        <= '0;
      shift        <= '0;
      sar          <= '0;
      bi           <= '0;
      div          <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (start_c) begin
        state <= S_ADDR;
        edges <= '0;
      end else if (stop_c) begin
        state <= S_IDLE;
      end else begin
        if (scl_rise) begin
          shift <= {shift[5:0], sda_s};
          if (edges != '1) edges <= en;
        end
        case (state)
          S_ADDR:
            if (scl_rise && en == EW'(RW_EDGE))
              state <= (addr_ok && sda_s) ? (mode_ext ? S_TRK_E : S_TRK_I) : S_WAIT;
          S_TRK_I:
            if (scl_fall && edges == EW'(ACK_EDGE)) begin
              state <= S_CNV_I;
              sar   <= MSB_TRIAL;
              bi    <= BW'(NB - 1);
              div   <= '0;
            end
          S_CNV_I:
            div <= (div == DW'(CONV_DIV - 1)) ? '0 : div + 1'b1;
          S_TRK_E:
            if (scl_rise && en == EW'(HOLD_EDGE)) begin
              state <= S_CNV_E;
              sar   <= MSB_TRIAL;
              bi    <= BW'(NB - 1);
            end
          default: ;
        endcase
        if (step) begin
          sar <= sar_nx;
          if (bi == '0) begin
            result       <= sar_nx;
            result_valid <= 1'b1;
            state        <= S_WAIT;
          end else begin
            bi <= bi - 1'b1;
          end
        end
      end
    end
  end

  assign track       = (state == S_TRK_I) || (state == S_TRK_E);
  assign hold        = (state == S_CNV_I) || (state == S_CNV_E);
  assign scl_stretch = (state == S_CNV_I);
  assign dac_code    = sar;
  assign mux_pos     = chan_sel;
  assign neg_gnd     = ~diff_en;
  assign mux_neg     = diff_en ? {chan_sel[CHW-1:1], ~chan_sel[0]} : '0;
endmodule

// File: rtl/i2c_sar_seq_chk.sv
module i2c_sar_seq_chk #(
  parameter int NB = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          track,
  input logic          hold,
  input logic          scl_stretch,
  input logic          result_valid,
  input logic [NB-1:0] dac_code,
  input logic          diff_en,
  input logic          neg_gnd,
  input logic          mode_ext
);
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!track && !hold && !scl_stretch && !result_valid));

  p_track_hold_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(track && hold));

  p_release_with_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_stretch) |-> result_valid);

  p_no_stretch_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ext && $stable(mode_ext) && !$past(scl_stretch)) |-> !scl_stretch);

  p_msb_trial_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> dac_code == {1'b1, {(NB-1){1'b0}}});

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_stretch_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_stretch |-> hold);

  p_gnd_when_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    neg_gnd == !diff_en);
endmodule

bind i2c_sar_seq i2c_sar_seq_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .track(track), .hold(hold),
  .scl_stretch(scl_stretch), .result_valid(result_valid),
  .dac_code(dac_code), .diff_en(diff_en), .neg_gnd(neg_gnd),
  .mode_ext(mode_ext)
);

// File: tb/tb_i2c_sar_seq.sv
module tb_i2c_sar_seq;
  localparam int NB = 10;
  localparam int DIV = 4;
  localparam int H = 10;
  localparam logic [6:0] ADDR = 7'h35;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic mode_ext = 1'b0, diff_en = 1'b0;
  logic [3:0] chan_sel = 4'd0;
  logic [NB-1:0] vin = '0;
  logic track, hold, scl_stretch, neg_gnd, result_valid;
  logic [3:0] mux_pos, mux_neg;
  logic [NB-1:0] dac_code, result;
  wire scl_line = m_scl & ~scl_stretch;
  wire cmp_in = (vin >= dac_code);

  int total = 0, bad = 0;
  int vld_cnt = 0, str_cyc = 0, trk_seen = 0, first_trial = -1;
  logic [NB-1:0] last_res = '0;
  logic hold_q = 1'b0;

  always #10 clk = ~clk;

  i2c_sar_seq #(.NB(NB), .CONV_DIV(DIV), .CHW(4)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(m_sda),
    .dev_addr(ADDR), .mode_ext(mode_ext), .chan_sel(chan_sel),
    .diff_en(diff_en), .cmp_in(cmp_in), .track(track), .hold(hold),
    .scl_stretch(scl_stretch), .mux_pos(mux_pos), .mux_neg(mux_neg),
    .neg_gnd(neg_gnd), .dac_code(dac_code), .result(result),
    .result_valid(result_valid)
  );

  always @(negedge clk) begin
    if (result_valid) begin vld_cnt++; last_res = result; end
    if (scl_stretch) str_cyc++;
    if (track || hold) trk_seen++;
    if (hold && !hold_q) first_trial = int'(dac_code);
    hold_q = hold;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    vld_cnt = 0; str_cyc = 0; trk_seen = 0; first_trial = -1;
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic raise();
    m_scl = 1'b1;
    wclk(1);
    while (!scl_line) wclk(1);
    wclk(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;
    wclk(H);
    raise();
    m_scl = 1'b0;
    wclk(4);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wclk(H);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b0; wclk(H);
    m_scl = 1'b0; wclk(4);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wclk(H);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b1; wclk(H);
  endtask

  task automatic addr_bits(input logic [6:0] a);
    for (int i = 6; i >= 0; i--) put_bit(a[i]);
  endtask

  task automatic t_reset();
    chk("R1 track", int'(track), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 stretch", int'(scl_stretch), 0);
    chk("R1 valid", int'(result_valid), 0);
  endtask

  task automatic t_internal(input logic [NB-1:0] v);
    vin = v; mode_ext = 1'b0; clr();
    i2c_start();
    addr_bits(ADDR);
    chk("R2 no track before rw", int'(track), 0);
    put_bit(1'b1);
    chk("R2 track after rw", int'(track), 1);
    m_sda = 1'b1; wclk(H);
    m_scl = 1'b1; wclk(H);
    m_scl = 1'b0; wclk(5);
    chk("R3 hold", int'(hold), 1);
    chk("R3 track low", int'(track), 0);
    chk("R3 stretch", int'(scl_stretch), 1);
    chk("R7 msb trial", first_trial, 1 << (NB - 1));
    raise();
    m_scl = 1'b0; wclk(4);
    chk("R4 stretch cycles", str_cyc, NB * DIV);
    chk("R4 result", int'(last_res), int'(v));
    chk("R8 one pulse", vld_cnt, 1);
    i2c_stop();
    chk("R8 result port", int'(result), int'(v));
  endtask

  task automatic t_external(input logic [NB-1:0] v);
    vin = v; mode_ext = 1'b1; clr();
    i2c_start();
    addr_bits(ADDR);
    put_bit(1'b1);
    chk("R5 track", int'(track), 1);
    put_bit(1'b1);
    put_bit(1'b1);
    chk("R5 no hold at 10", int'(hold), 0);
    put_bit(1'b1);
    chk("R5 hold at 11", int'(hold), 1);
    chk("R7 msb trial ext", first_trial, 1 << (NB - 1));
    put_bit(1'b1);
    chk("R6 one step", int'(dac_code),
        int'((v & 10'h200) | 10'h100));
    for (int i = 0; i < NB - 2; i++) put_bit(1'b1);
    chk("R6 not early", vld_cnt, 0);
    put_bit(1'b1);
    chk("R6 valid on 10th", vld_cnt, 1);
    chk("R6 result", int'(last_res), int'(v));
    chk("R5 no stretch", str_cyc, 0);
    i2c_stop();
  endtask

  task automatic t_reject();
    mode_ext = 1'b0; clr();
    i2c_start();
    addr_bits(ADDR);
    put_bit(1'b0);
    put_bit(1'b1);
    put_bit(1'b1);
    i2c_stop();
    chk("R9 write no track", trk_seen, 0);
    clr();
    i2c_start();
    addr_bits(ADDR ^ 7'h01);
    put_bit(1'b1);
    put_bit(1'b1);
    put_bit(1'b1);
    i2c_stop();
    chk("R9 mismatch no track", trk_seen, 0);
  endtask

  task automatic t_abort();
    mode_ext = 1'b1; vin = 10'd300; clr();
    i2c_start();
    addr_bits(ADDR);
    put_bit(1'b1);
    chk("R10 track before restart", int'(track), 1);
    i2c_start();
    chk("R10 restart drops track", int'(track), 0);
    addr_bits(ADDR);
    put_bit(1'b1);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    chk("R10 in hold", int'(hold), 1);
    i2c_stop();
    chk("R10 stop drops hold", int'(hold), 0);
    chk("R10 no result", vld_cnt, 0);
  endtask

  task automatic t_chan();
    chan_sel = 4'd5; diff_en = 1'b0; wclk(2);
    chk("R11 pos", int'(mux_pos), 5);
    chk("R11 gnd", int'(neg_gnd), 1);
    chk("R11 neg zero", int'(mux_neg), 0);
    diff_en = 1'b1; wclk(2);
    chk("R11 pair of 5", int'(mux_neg), 4);
    chk("R11 not gnd", int'(neg_gnd), 0);
    chan_sel = 4'd10; wclk(2);
    chk("R11 pair of 10", int'(mux_neg), 11);
    diff_en = 1'b0; chan_sel = 4'd0;
  endtask

  initial begin
    wclk(3);
    t_reset();
    rst_n = 1'b1;
    wclk(3);
    t_reset();
    t_internal(10'h2A5);
    t_internal(10'd0);
    t_internal(10'd1023);
    t_external(10'd513);
    t_external(10'h155);
    t_reject();
    t_abort();
    t_internal(10'd1);
    t_chan();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule